// File: doc/BRIEF.md
# Nesting Programmable-Priority Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt request lines, up to 256 of them, numbered from 0 upward. Every line carries its own 8-bit urgency value and an enable bit. Both are set through a small write port addressed by line number, and either can be changed at run time. A smaller value means a more urgent line. When two values are equal, the lower line number wins. From all lines that are requesting, enabled and not already in service, the block picks the most urgent one. It presents that line's number and a valid flag to the processor.

Interrupts that are in service are kept on a stack of configurable depth. The urgency at the top of the stack is the running priority. A new request is only offered if its value is strictly below the running priority, so a more urgent interrupt preempts the current one. The processor takes the offered interrupt with an accept strobe, which pushes it onto the stack. It signals completion with an end-of-interrupt strobe, which pops the stack, so the interrupted service resumes.

Top module: `nest_irq_ctrl`

## Requirements
- R1: During and after synchronous reset, `irq_valid` is low and `run_prio` is 0x100 (the stack is empty). `err_flag` is low, every line is disabled, and every urgency value is 0x80.
- R2: Among the offered candidates, the line with the smallest urgency value is presented. When values tie, the lowest line number is presented.
- R3: A line is a candidate only if it is requesting, enabled and not in service, and its urgency value is strictly below `run_prio`. A candidate with a value equal to `run_prio` is not offered.
- R4: `irq_valid` and `irq_id` are registered. They reflect the inputs and state of the previous clock cycle. In the cycle after any `irq_accept` or `irq_eoi` strobe, `irq_valid` is low.
- R5: An `irq_accept` while `irq_valid` is high pushes the presented line and its current urgency value onto the stack. From the next cycle on, `run_prio` equals that value. An `irq_accept` while `irq_valid` is low is ignored.
- R6: An `irq_eoi` pops the top stack entry and ends that line's in-service state. `run_prio` then returns to the entry below, or to 0x100 if the stack is now empty, so the interrupted line's level is in force again.
- R7: An `irq_eoi` with an empty stack, or an accept that would push onto a full stack, leaves the stack unchanged and sets `err_flag`. `err_flag` stays high until reset.
- R8: A `cfg_we_prio` pulse writes `cfg_prio` into the urgency value of line `cfg_addr`. A `cfg_we_en` pulse writes `cfg_en` into its enable bit. The two strobes are independent.
- R9: When `irq_accept` and `irq_eoi` arrive in the same cycle, the end-of-interrupt is carried out and the accept is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Level request per line |
| cfg_we_prio | input | 1 | Write strobe for the urgency value |
| cfg_we_en | input | 1 | Write strobe for the enable bit |
| cfg_addr | input | IDX_W | Line number targeted by the write |
| cfg_prio | input | 8 | Urgency value to write |
| cfg_en | input | 1 | Enable value to write |
| irq_accept | input | 1 | Processor takes the presented interrupt |
| irq_eoi | input | 1 | Processor finished the top interrupt |
| irq_valid | output | 1 | An interrupt is offered |
| irq_id | output | IDX_W | Number of the offered line |
| run_prio | output | 9 | Running priority; 0x100 when nothing is in service |
| err_flag | output | 1 | Sticky misuse flag |

## Verification
The properties assume that the strobes are single-cycle pulses and that the processor accepts only what the block currently offers. The monotonic checks on `run_prio` across push and pop depend on that discipline. The bench drives every strobe for exactly one cycle at the falling edge. It raises `irq_accept` only after it has seen `irq_valid` high, except in the deliberate ignored-accept and misuse cases. It changes requests and configuration only between strobes, so each property sees one event at a time.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam logic [PRIO_W-1:0] PRIO_RST = 8'h80;
  localparam logic [RUN_W-1:0]  RUN_IDLE = 9'h100;
endpackage

// File: rtl/nirq_cfg_regs.sv
module nirq_cfg_regs
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int IDX_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_prio,
  input  logic                       we_en,
  input  logic [IDX_W-1:0]           addr,
  input  logic [PRIO_W-1:0]          wprio,
  input  logic                       wen,
  output logic [NUM_IRQ*PRIO_W-1:0]  prio_flat,
  output logic [NUM_IRQ-1:0]         en_vec
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_flat[g*PRIO_W +: PRIO_W] <= PRIO_RST;
        en_vec[g]                     <= 1'b0;
      end else if (addr == IDX_W'(g)) begin
        if (we_prio) prio_flat[g*PRIO_W +: PRIO_W] <= wprio;
        if (we_en)   en_vec[g]                     <= wen;
      end
    end
  end
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int IDX_W   = 8
) (
  input  logic [NUM_IRQ-1:0]         eligible,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prio_flat,
  input  logic [RUN_W-1:0]           run_prio,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx
);
  logic [RUN_W-1:0] best;

  // Ascending scan with a strict compare keeps the lower number on ties;
  // seeding with the running priority enforces the preemption threshold.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = run_prio;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i] && ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < best)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
      end
    end
  end
endmodule

// File: rtl/nirq_stack.sv
module nirq_stack
  import nirq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [IDX_W-1:0]  push_id,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [IDX_W-1:0]  top_id,
  output logic [RUN_W-1:0]  run_prio,
  output logic              empty,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  id_mem   [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [CW-1:0]     count;
  logic [AW-1:0]     top_a;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign top_a = empty ? '0 : AW'(count - 1'b1);

  always_ff @(posedge clk) begin
    if (push) begin
      id_mem[AW'(count)]   <= push_id;
      prio_mem[AW'(count)] <= push_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (push) count <= count + 1'b1;
    else if (pop)  count <= count - 1'b1;
  end

  assign top_id   = id_mem[top_a];
  assign run_prio = empty ? RUN_IDLE : {1'b0, prio_mem[top_a]};
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ     = 256,
  parameter int STACK_DEPTH = 8,
  parameter int IDX_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               cfg_we_prio,
  input  logic               cfg_we_en,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [7:0]         cfg_prio,
  input  logic               cfg_en,
  input  logic               irq_accept,
  input  logic               irq_eoi,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_id,
  output logic [8:0]         run_prio,
  output logic               err_flag
);
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [NUM_IRQ-1:0]        en_vec;
  logic [NUM_IRQ-1:0]        active;
  logic [NUM_IRQ-1:0]        eligible;
  logic                      hit;
  logic [IDX_W-1:0]          pick;
  logic [IDX_W-1:0]          top_id;
  logic                      st_empty, st_full;
  logic                      do_push, do_pop, misuse;
  logic [PRIO_W-1:0]         sel_prio;

  nirq_cfg_regs #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .we_prio(cfg_we_prio), .we_en(cfg_we_en),
    .addr(cfg_addr), .wprio(cfg_prio), .wen(cfg_en),
    .prio_flat(prio_flat), .en_vec(en_vec)
  );

  assign eligible = irq_req & en_vec & ~active;

  nirq_arbiter #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
    .eligible(eligible), .prio_flat(prio_flat), .run_prio(run_prio),
    .hit(hit), .idx(pick)
  );

  always_comb begin
    sel_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (irq_id == IDX_W'(i)) sel_prio = prio_flat[i*PRIO_W +: PRIO_W];
  end

  assign do_pop  = irq_eoi && !st_empty;
  assign do_push = irq_accept && irq_valid && !irq_eoi && !st_full;
  assign misuse  = (irq_eoi && st_empty) ||
                   (irq_accept && irq_valid && !irq_eoi && st_full);

  nirq_stack #(.DEPTH(STACK_DEPTH), .IDX_W(IDX_W)) u_stk (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
    .push_id(irq_id), .push_prio(sel_prio),
    .top_id(top_id), .run_prio(run_prio),
    .empty(st_empty), .full(st_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
    end else begin
      if (do_push) active[irq_id] <= 1'b1;
      if (do_pop)  active[top_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      err_flag  <= 1'b0;
    end else begin
      irq_valid <= (irq_accept || irq_eoi) ? 1'b0 : hit;
      irq_id    <= pick;
      if (misuse) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/nirq_checker.sv
module nirq_checker (
  input logic       clk,
  input logic       rst,
  input logic       irq_accept,
  input logic       irq_eoi,
  input logic       irq_valid,
  input logic [8:0] run_prio,
  input logic       err_flag
);
  p_valid_drops_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_accept || irq_eoi) |=> !irq_valid);

  p_push_lowers_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_accept && irq_valid && !irq_eoi) |=> (run_prio <= $past(run_prio)));

  p_idle_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_accept && !irq_valid && !irq_eoi) |=> $stable(run_prio));

  p_pop_raises_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_eoi && run_prio != 9'h100) |=> (run_prio > $past(run_prio)));

  p_empty_eoi_err_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_eoi && run_prio == 9'h100) |=> err_flag);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind nest_irq_ctrl nirq_checker u_chk (
  .clk(clk), .rst(rst), .irq_accept(irq_accept), .irq_eoi(irq_eoi),
  .irq_valid(irq_valid), .run_prio(run_prio), .err_flag(err_flag)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0;
  logic          cfg_we_prio = 1'b0, cfg_we_en = 1'b0, cfg_en = 1'b0;
  logic [IW-1:0] cfg_addr = '0;
  logic [7:0]    cfg_prio = '0;
  logic          irq_accept = 1'b0, irq_eoi = 1'b0;
  logic          irq_valid, err_flag;
  logic [IW-1:0] irq_id;
  logic [8:0]    run_prio;

  int applied = 0;
  int bad     = 0;

  // {request vector, expected valid, expected id}
  localparam logic [20:0] VEC [8] = '{
    {16'h0000, 1'b0, 4'd0},
    {16'h0008, 1'b1, 4'd3},
    {16'h1008, 1'b1, 4'd12},
    {16'h1220, 1'b1, 4'd5},
    {16'h0003, 1'b1, 4'd0},
    {16'h000A, 1'b1, 4'd1},
    {16'h8000, 1'b1, 4'd15},
    {16'h8200, 1'b1, 4'd9}
  };

  nest_irq_ctrl #(.NUM_IRQ(N), .STACK_DEPTH(2)) u_nest_irq_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .cfg_we_prio(cfg_we_prio), .cfg_we_en(cfg_we_en), .cfg_addr(cfg_addr),
    .cfg_prio(cfg_prio), .cfg_en(cfg_en),
    .irq_accept(irq_accept), .irq_eoi(irq_eoi),
    .irq_valid(irq_valid), .irq_id(irq_id),
    .run_prio(run_prio), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic offer(string tag, bit v, int id);
    chk({tag, " valid"}, int'(irq_valid), int'(v));
    if (v) chk({tag, " id"}, int'(irq_id), id);
  endtask

  task automatic cfg(int a, bit wp, int p, bit we, bit e);
    cfg_addr = IW'(a); cfg_we_prio = wp; cfg_prio = 8'(p);
    cfg_we_en = we; cfg_en = e;
    step();
    cfg_we_prio = 1'b0; cfg_we_en = 1'b0;
  endtask

  task automatic pulse(bit acc, bit eoi);
    irq_accept = acc; irq_eoi = eoi;
    step();
    irq_accept = 1'b0; irq_eoi = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state, all lines disabled
    chk("R1 valid", int'(irq_valid), 0);
    chk("R1 run_prio", int'(run_prio), 'h100);
    chk("R1 err", int'(err_flag), 0);
    irq_req = 16'h0044;
    step();
    offer("R1 disabled", 1'b0, 0);
    // R1/R8: reset urgency 0x80, shown against 0x81 and 0x7F
    cfg(2, 0, 0, 1, 1);
    cfg(6, 1, 'h81, 1, 1);
    step();
    offer("R1 reset prio vs 0x81", 1'b1, 2);
    cfg(6, 1, 'h7F, 0, 0);
    step();
    offer("R8 prio write", 1'b1, 6);
    irq_req = '0;

    for (int i = 0; i < N; i++) cfg(i, 0, 0, 1, 1);
    cfg(6, 1, 'h80, 0, 0);
    cfg(5, 1, 'h10, 0, 0);
    cfg(9, 1, 'h10, 0, 0);
    cfg(3, 1, 'hF0, 0, 0);
    cfg(12, 1, 'h40, 0, 0);

    // R2/R4: table walk, one registered cycle per vector
    for (int i = 0; i < 8; i++) begin
      irq_req = VEC[i][20:5];
      step();
      offer("R2 table", VEC[i][4], int'(VEC[i][3:0]));
    end
    cfg(9, 0, 0, 1, 0);
    step();
    offer("R3 disabled line skipped", 1'b1, 15);
    cfg(9, 0, 0, 1, 1);

    // Nesting
    irq_req = 16'h1000;
    step();
    offer("R3 idle stack", 1'b1, 12);
    pulse(1, 0);
    chk("R4 valid after accept", int'(irq_valid), 0);
    chk("R5 run after push", int'(run_prio), 'h40);
    step();
    offer("R3 active excluded", 1'b0, 0);
    irq_req = 16'h1002;
    step();
    offer("R3 less urgent held", 1'b0, 0);
    irq_req = 16'h1022;
    step();
    offer("R3 preempt", 1'b1, 5);
    pulse(1, 0);
    chk("R5 run nested", int'(run_prio), 'h10);
    irq_req = 16'h1222;
    step();
    offer("R3 equal not offered", 1'b0, 0);
    cfg(7, 1, 'h08, 0, 0);
    irq_req = 16'h12A2;
    step();
    offer("R3 deeper preempt", 1'b1, 7);
    pulse(1, 0);
    chk("R7 full push ignored", int'(run_prio), 'h10);
    chk("R7 full push err", int'(err_flag), 1);
    irq_req = 16'h1222;
    step();
    pulse(0, 1);
    chk("R6 resume level", int'(run_prio), 'h40);
    chk("R4 valid after eoi", int'(irq_valid), 0);
    step();
    offer("R6 popped line eligible", 1'b1, 5);
    irq_req = 16'h1002;
    step();
    offer("R6 nothing above 0x40", 1'b0, 0);
    irq_req = 16'h1022;
    step();
    offer("R9 setup", 1'b1, 5);
    pulse(1, 1);
    chk("R9 eoi wins", int'(run_prio), 'h100);
    step();
    offer("R9 line still offered", 1'b1, 5);
    chk("R7 sticky", int'(err_flag), 1);

    // Misuse after a fresh reset
    irq_req = '0;
    do_reset();
    chk("R7 cleared by reset", int'(err_flag), 0);
    pulse(1, 0);
    chk("R5 idle accept ignored", int'(run_prio), 'h100);
    chk("R5 idle accept no err", int'(err_flag), 0);
    pulse(0, 1);
    chk("R7 empty eoi err", int'(err_flag), 1);
    chk("R7 empty eoi run", int'(run_prio), 'h100);
    step();
    summary();
  end
endmodule